// File: doc/BRIEF.md
# Per-Plane Header Key Extractor and Hasher

This block sits in the preprocessing part of a virtualised packet pipeline. Each packet arrives on a 64-bit word stream. The first word of every packet is a 64-bit internal metadata word, and the packet data follows it. The block holds the metadata word and the first five data words (40 bytes). From those bytes it builds a 256-bit exact-match key, reduces the key to a 32-bit CRC, and writes the CRC into the hash field of the metadata word. The held words are then emitted, and the rest of the packet streams through.

The plane ID in the top byte of the metadata word selects one of several configuration registers. Each register chooses how the key is built: generic 64-bit word selection, an IPv4 flow tuple, an IPv4 destination joined with path-selection bits, or an IPv6 destination. While the block is holding words or emitting them, it drops its input ready signal.

Top module: `hdr_hash_ext`

## Requirements
- R1: After reset, out_valid_o is low and in_ready_o is high.
- R2: Data bytes are numbered from 0, starting at the most significant byte of the first word after the metadata word. Configuration bits [2:0] hold the mode, and code 1 selects generic mode. In generic mode, key bits [255-64k -: 64] for slot k (k = 0..3) hold data word sel_k. Here sel_k = cfg[5+2k:4+2k] and picks one of the words covering bytes 0..31. A slot whose enable bit cfg[12+k] is clear is zero. The hash is a CRC-32 of the key with polynomial 0x04C11DB7 and initial value all ones. Key bit 255 is fed first, with no reflection and no final inversion.
- R3: Mode code 2 builds a flow key. Key[255:160] holds bytes 12..23 in order, key[159:152] holds byte 9, and every other key bit is zero.
- R4: Mode code 3 builds a splicing key. Key[255:224] holds bytes 16..19. Key[223:216] holds the byte at offset cfg[21:16], masked to its low w bits, where w = cfg[27:24] clamped to the range 1..8. All other key bits are zero. Two packets that differ only in those path bits produce different hashes. Bits above the mask have no effect on the hash.
- R5: Mode code 4 builds an IPv6 key. Key[255:128] holds bytes 24..39, and the rest of the key is zero.
- R6: The metadata word is emitted with bits [31:0] replaced by the hash and bits [63:32] unchanged. The plane ID sits in bits [63:56]. If the plane ID is not below NUM_PLANES, or the plane's mode code is not 1..4, the metadata word is emitted unchanged.
- R7: Every word after the metadata word is emitted unchanged and in order. Start of packet is marked on the first output word only, and end of packet on the last output word only.
- R8: Bytes past the end of the packet read as zero for key building. A packet of only the metadata word is supported.
- R9: While an output word is offered and not taken, in_ready_o is low, and the word and its markers stay stable until they are taken.
- R10: A configuration write with cfg_addr_i = p changes only plane p's register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | PLANE_W | Plane whose register is written |
| cfg_wdata_i | input | 32 | Configuration value |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Input word accepted when high with valid |
| in_data_i | input | 64 | Input word |
| in_sop_i | input | 1 | Input word is the metadata word |
| in_eop_i | input | 1 | Input word is the last of its packet |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Downstream takes the output word |
| out_data_o | output | 64 | Output word |
| out_sop_o | output | 1 | Output word is the metadata word |
| out_eop_o | output | 1 | Output word is the last of its packet |

## Verification
The assertions assume that the upstream side keeps in_valid_i and its word steady until in_ready_o takes the word. They also assume that each packet begins with one word marked start of packet and closes with one word marked end of packet. Without the first assumption, the stability check on stalled outputs would not hold during pass-through. The stimulus drives every word through a single task that holds it until a sampled ready, and it frames each packet correctly. Downstream stalls come from an alternating ready pattern on half of the packets.

// File: rtl/hk_pkg.sv
package hk_pkg;
  localparam int WORD_W = 64;
  localparam int KEY_W  = 256;
  localparam int HASH_W = 32;
  localparam int CFG_W  = 32;
  localparam int NUM_SLOTS = KEY_W / WORD_W;
  localparam logic [HASH_W-1:0] CRC_POLY = 32'h04C11DB7;

  localparam logic [2:0] MODE_GENERIC = 3'd1;
  localparam logic [2:0] MODE_FLOW    = 3'd2;
  localparam logic [2:0] MODE_SPLICE  = 3'd3;
  localparam logic [2:0] MODE_V6      = 3'd4;

  typedef struct packed {
    logic [3:0]             splice_w;
    logic [5:0]             splice_off;
    logic [NUM_SLOTS-1:0]   slot_en;
    logic [2*NUM_SLOTS-1:0] slot_sel;
    logic [2:0]             mode;
  } cfg_t;

  function automatic logic [HASH_W-1:0] crc_key(input logic [KEY_W-1:0] k);
    logic [HASH_W-1:0] c;
    c = '1;
    for (int i = KEY_W - 1; i >= 0; i--) begin
      if (c[HASH_W-1] ^ k[i]) c = {c[HASH_W-2:0], 1'b0} ^ CRC_POLY;
      else                    c = {c[HASH_W-2:0], 1'b0};
    end
    return c;
  endfunction
endpackage

// File: rtl/hk_cfg_regs.sv
module hk_cfg_regs
  import hk_pkg::*;
#(
  parameter int NUM_PLANES = 4,
  localparam int PLANE_W = (NUM_PLANES > 1) ? $clog2(NUM_PLANES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [PLANE_W-1:0] waddr_i,
  input  logic [CFG_W-1:0]   wdata_i,
  input  logic [PLANE_W-1:0] raddr_i,
  output cfg_t               rcfg_o
);
  cfg_t [NUM_PLANES-1:0] regs;
  logic unused_wbits;
  assign unused_wbits = ^{wdata_i[31:28], wdata_i[23:22], wdata_i[3]};

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
    cfg_t r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        r_q <= '0;
      end else if (we_i && waddr_i == PLANE_W'(p)) begin
        r_q <= '{splice_w:   wdata_i[27:24],
                 splice_off: wdata_i[21:16],
                 slot_en:    wdata_i[15:12],
                 slot_sel:   wdata_i[11:4],
                 mode:       wdata_i[2:0]};
      end
    end
    assign regs[p] = r_q;
  end

  assign rcfg_o = regs[raddr_i];
endmodule

// File: rtl/hk_key_build.sv
module hk_key_build
  import hk_pkg::*;
#(
  parameter int HDR_WORDS = 5,
  localparam int HDR_BYTES = HDR_WORDS * 8,
  localparam int HDR_BITS  = HDR_WORDS * WORD_W
) (
  input  logic [HDR_BITS-1:0] hdr_i,
  input  cfg_t                cfg_i,
  output logic [KEY_W-1:0]    key_o,
  output logic                key_ok_o
);
  function automatic logic [7:0] byte_at(input logic [HDR_BITS-1:0] h, input int idx);
    if (idx < HDR_BYTES) return h[HDR_BITS-1-8*idx -: 8];
    return 8'h00;
  endfunction

  logic [3:0] path_w;
  logic [7:0] path_mask;

  always_comb begin
    path_w = cfg_i.splice_w;
    if (path_w == 4'd0)      path_w = 4'd1;
    else if (path_w > 4'd8)  path_w = 4'd8;
    path_mask = 8'hFF >> (4'd8 - path_w);
  end

  always_comb begin
    key_o    = '0;
    key_ok_o = 1'b1;
    case (cfg_i.mode)
      MODE_GENERIC: begin
        for (int k = 0; k < NUM_SLOTS; k++) begin
          if (cfg_i.slot_en[k])
            key_o[KEY_W-1-WORD_W*k -: WORD_W] =
              hdr_i[HDR_BITS-1-WORD_W*int'(cfg_i.slot_sel[2*k +: 2]) -: WORD_W];
        end
      end
      MODE_FLOW: begin
        for (int i = 0; i < 12; i++) key_o[KEY_W-1-8*i -: 8] = byte_at(hdr_i, 12 + i);
        key_o[KEY_W-97 -: 8] = byte_at(hdr_i, 9);
      end
      MODE_SPLICE: begin
        for (int i = 0; i < 4; i++) key_o[KEY_W-1-8*i -: 8] = byte_at(hdr_i, 16 + i);
        key_o[KEY_W-33 -: 8] = byte_at(hdr_i, int'(cfg_i.splice_off)) & path_mask;
      end
      MODE_V6: begin
        for (int i = 0; i < 16; i++) key_o[KEY_W-1-8*i -: 8] = byte_at(hdr_i, 24 + i);
      end
      default: key_ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/hk_crc32.sv
module hk_crc32
  import hk_pkg::*;
(
  input  logic [KEY_W-1:0]  key_i,
  output logic [HASH_W-1:0] crc_o
);
  assign crc_o = crc_key(key_i);
endmodule

// File: rtl/hdr_hash_ext.sv
module hdr_hash_ext
  import hk_pkg::*;
#(
  parameter int NUM_PLANES = 4,
  parameter int HDR_WORDS  = 5,
  localparam int PLANE_W  = (NUM_PLANES > 1) ? $clog2(NUM_PLANES) : 1,
  localparam int CNT_W    = $clog2(HDR_WORDS + 2),
  localparam int HDR_BITS = HDR_WORDS * WORD_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [PLANE_W-1:0] cfg_addr_i,
  input  logic [CFG_W-1:0]   cfg_wdata_i,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [WORD_W-1:0]  in_data_i,
  input  logic               in_sop_i,
  input  logic               in_eop_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [WORD_W-1:0]  out_data_o,
  output logic               out_sop_o,
  output logic               out_eop_o
);
  typedef enum logic [1:0] {ST_COLLECT, ST_DRAIN, ST_PASS} state_e;

  state_e             state_q;
  logic [CNT_W-1:0]   cnt_q, idx_q, n_q;
  logic               eop_q;
  logic [WORD_W-1:0]  meta_q;
  logic [WORD_W-1:0]  data_q [HDR_WORDS];
  logic [HDR_BITS-1:0] hdr_flat;
  cfg_t               cfg;
  logic [KEY_W-1:0]   key;
  logic               key_ok;
  logic [HASH_W-1:0]  hash;
  logic               plane_ok;
  logic [WORD_W-1:0]  meta_out;

  for (genvar w = 0; w < HDR_WORDS; w++) begin : g_flat
    assign hdr_flat[HDR_BITS-1-WORD_W*w -: WORD_W] = data_q[w];
  end

  hk_cfg_regs #(.NUM_PLANES(NUM_PLANES)) i_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .waddr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .raddr_i(meta_q[56 +: PLANE_W]), .rcfg_o(cfg)
  );

  hk_key_build #(.HDR_WORDS(HDR_WORDS)) i_key (
    .hdr_i(hdr_flat), .cfg_i(cfg), .key_o(key), .key_ok_o(key_ok)
  );

  hk_crc32 i_crc (.key_i(key), .crc_o(hash));

  assign plane_ok = int'(meta_q[63:56]) < NUM_PLANES;
  assign meta_out = (plane_ok && key_ok) ? {meta_q[WORD_W-1:HASH_W], hash} : meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_COLLECT;
      cnt_q   <= '0;
      idx_q   <= '0;
      n_q     <= '0;
      eop_q   <= 1'b0;
      meta_q  <= '0;
      for (int w = 0; w < HDR_WORDS; w++) data_q[w] <= '0;
    end else begin
      case (state_q)
        ST_COLLECT: if (in_valid_i) begin
          if (cnt_q == '0 || in_sop_i) begin
            meta_q <= in_data_i;
            for (int w = 0; w < HDR_WORDS; w++) data_q[w] <= '0;
            if (in_eop_i) begin
              n_q     <= CNT_W'(1);
              eop_q   <= 1'b1;
              cnt_q   <= '0;
              state_q <= ST_DRAIN;
            end else begin
              cnt_q <= CNT_W'(1);
            end
          end else begin
            data_q[cnt_q - CNT_W'(1)] <= in_data_i;
            if (in_eop_i || cnt_q == CNT_W'(HDR_WORDS)) begin
              n_q     <= cnt_q + CNT_W'(1);
              eop_q   <= in_eop_i;
              cnt_q   <= '0;
              state_q <= ST_DRAIN;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
        end
        ST_DRAIN: if (out_ready_i) begin
          if (idx_q == n_q - CNT_W'(1)) begin
            idx_q   <= '0;
            state_q <= eop_q ? ST_COLLECT : ST_PASS;
          end else begin
            idx_q <= idx_q + CNT_W'(1);
          end
        end
        ST_PASS: if (in_valid_i && out_ready_i && in_eop_i) state_q <= ST_COLLECT;
        default: state_q <= ST_COLLECT;
      endcase
    end
  end

  always_comb begin
    in_ready_o  = 1'b0;
    out_valid_o = 1'b0;
    out_data_o  = meta_out;
    out_sop_o   = 1'b0;
    out_eop_o   = 1'b0;
    case (state_q)
      ST_COLLECT: in_ready_o = 1'b1;
      ST_DRAIN: begin
        out_valid_o = 1'b1;
        out_sop_o   = (idx_q == '0);
        out_eop_o   = eop_q && (idx_q == n_q - CNT_W'(1));
        out_data_o  = (idx_q == '0) ? meta_out : data_q[idx_q - CNT_W'(1)];
      end
      ST_PASS: begin
        in_ready_o  = out_ready_i;
        out_valid_o = in_valid_i;
        out_data_o  = in_data_i;
        out_eop_o   = in_eop_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/hdr_hash_ext_chk.sv
module hdr_hash_ext_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic        in_ready_o,
  input logic [63:0] in_data_i,
  input logic        in_sop_i,
  input logic        out_valid_o,
  input logic        out_ready_i,
  input logic [63:0] out_data_o,
  input logic        out_sop_o,
  input logic        out_eop_o
);
  logic        open_q;
  logic [31:0] meta_hi_q;
  logic        unused_lo;
  assign unused_lo = ^in_data_i[31:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q    <= 1'b0;
      meta_hi_q <= '0;
    end else begin
      if (in_valid_i && in_ready_o && in_sop_i) meta_hi_q <= in_data_i[63:32];
      if (out_valid_o && out_ready_i) begin
        if (out_eop_o)      open_q <= 1'b0;
        else if (out_sop_o) open_q <= 1'b1;
      end
    end
  end

  a_r9_stall_blocks_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);

  a_r9_stalled_word_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_data_o) && $stable(out_sop_o) && $stable(out_eop_o)));

  a_r7_sop_starts_packet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_sop_o) |-> !open_q);

  a_r7_body_inside_packet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_sop_o) |-> open_q);

  a_r6_meta_upper_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_sop_o) |-> (out_data_o[63:32] == meta_hi_q));
endmodule

bind hdr_hash_ext hdr_hash_ext_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_data_i(in_data_i), .in_sop_i(in_sop_i),
  .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_data_o(out_data_o),
  .out_sop_o(out_sop_o), .out_eop_o(out_eop_o)
);

// File: tb/test_hdr_hash_ext.sv
module test_hdr_hash_ext;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_ni;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        in_valid, in_ready, in_sop, in_eop;
  logic [63:0] in_data;
  logic        out_valid, out_ready, out_sop, out_eop;
  logic [63:0] out_data;

  hdr_hash_ext i_hdr_hash_ext (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .in_sop_i(in_sop), .in_eop_i(in_eop),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .out_sop_o(out_sop), .out_eop_o(out_eop)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] cfg_m [4] = '{default: '0};
  logic [63:0] pkt [16];
  int          plen;
  logic [63:0] rx_d [16];
  logic        rx_s [16], rx_e [16];
  int          rx_n;

  // {stall, plane[2:0], len[3:0], pad, seed[15:0]}
  localparam logic [31:0] VEC [8] = '{
    {1'b0, 3'd0, 4'd6, 8'h00, 16'h1111},
    {1'b1, 3'd0, 4'd9, 8'h00, 16'h2222},
    {1'b0, 3'd1, 4'd4, 8'h00, 16'h3333},
    {1'b1, 3'd1, 4'd8, 8'h00, 16'h4444},
    {1'b0, 3'd2, 4'd6, 8'h00, 16'h5555},
    {1'b1, 3'd3, 4'd7, 8'h00, 16'h6666},
    {1'b0, 3'd7, 4'd5, 8'h00, 16'h7777},
    {1'b1, 3'd3, 4'd3, 8'h00, 16'h8888}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pbyte(input int i);
    int w;
    w = 1 + i / 8;
    if (i >= 40 || w >= plen) return 8'h00;
    return pkt[w][63-8*(i%8) -: 8];
  endfunction

  function automatic logic [31:0] ref_crc(input logic [255:0] k);
    logic [31:0] c;
    logic        fb;
    c = 32'hFFFF_FFFF;
    for (int i = 255; i >= 0; i--) begin
      fb = c[31] ^ k[i];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ 32'h04C1_1DB7;
    end
    return c;
  endfunction

  function automatic logic [63:0] exp_meta();
    logic [63:0]  m;
    logic [31:0]  c;
    logic [255:0] k;
    int           pl, w, sel;
    m  = pkt[0];
    pl = int'(m[63:56]);
    k  = '0;
    if (pl >= 4) return m;
    c = cfg_m[pl];
    case (c[2:0])
      3'd1: for (int s = 0; s < 4; s++) begin
              sel = int'(c[4+2*s +: 2]);
              if (c[12+s]) for (int b = 0; b < 8; b++) k[255-64*s-8*b -: 8] = pbyte(8*sel + b);
            end
      3'd2: begin
              for (int i = 0; i < 12; i++) k[255-8*i -: 8] = pbyte(12 + i);
              k[159:152] = pbyte(9);
            end
      3'd3: begin
              for (int i = 0; i < 4; i++) k[255-8*i -: 8] = pbyte(16 + i);
              w = int'(c[27:24]);
              if (w == 0) w = 1;
              if (w > 8)  w = 8;
              k[223:216] = pbyte(int'(c[21:16])) & (8'hFF >> (8 - w));
            end
      3'd4: for (int i = 0; i < 16; i++) k[255-8*i -: 8] = pbyte(24 + i);
      default: return m;
    endcase
    return {m[63:32], ref_crc(k)};
  endfunction

  function automatic string mode_tag(input int pl);
    if (pl >= 4) return "R6";
    case (cfg_m[pl][2:0])
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic gen(input int plane, input int len, input logic [15:0] seed);
    plen = len;
    pkt[0] = {8'(plane), 8'h5A, 16'hC0DE, 32'hDEAD_BEEF};
    for (int i = 1; i < len; i++)
      pkt[i] = {seed, 8'(i), seed[7:0] ^ 8'(i * 37), seed ^ 16'(i * 4099), 16'h1F00 + 16'(i)};
  endtask

  task automatic write_cfg(input int p, input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'(p); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_m[p] = v;
  endtask

  task automatic drive();
    for (int i = 0; i < plen; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = pkt[i]; in_sop = (i == 0); in_eop = (i == plen - 1);
      #2;
      while (!in_ready) begin
        @(negedge clk);
        #2;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic recv(input bit stall);
    bit          tog, held, done;
    logic [63:0] hd;
    tog = 1'b0; held = 1'b0; done = 1'b0; hd = '0;
    rx_n = 0;
    while (!done) begin
      @(negedge clk);
      tog = ~tog;
      out_ready = stall ? tog : 1'b1;
      #1;
      if (out_valid) begin
        if (!out_ready) begin
          chk(in_ready == 1'b0, "R9 input blocked during stall", 64'(in_ready), 64'd0);
          if (held) chk(out_data == hd, "R9 stalled word stable", out_data, hd);
          held = 1'b1; hd = out_data;
        end else begin
          if (held) chk(out_data == hd, "R9 stalled word kept until taken", out_data, hd);
          held = 1'b0;
          if (rx_n < 16) begin
            rx_d[rx_n] = out_data; rx_s[rx_n] = out_sop; rx_e[rx_n] = out_eop;
          end
          rx_n++;
          if (out_eop) done = 1'b1;
        end
      end
    end
  endtask

  task automatic run_pkt(input bit stall, input string tag);
    logic [63:0] em;
    em = exp_meta();
    fork
      drive();
      recv(stall);
    join
    chk(rx_n == plen, "R7 word count", 64'(rx_n), 64'(plen));
    if (rx_n >= 1 && rx_n <= 16) begin
      chk(rx_d[0] == em, {tag, " metadata hash"}, rx_d[0], em);
      for (int i = 0; i < rx_n; i++)
        chk(rx_s[i] == (i == 0) && rx_e[i] == (i == plen - 1) && (i == 0 || rx_d[i] == pkt[i]),
            "R7 word data and markers", rx_d[i], pkt[i]);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] h1, h2;
    rst_ni = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    in_valid = 1'b0; in_data = '0; in_sop = 1'b0; in_eop = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 idle after reset", {62'd0, out_valid, in_ready}, 64'd1);

    // R2 generic: slots use words 2,0,3(off),1; R3 flow; R4 splice off 33 width 5; R5 v6
    write_cfg(0, 32'h0000_B721);
    write_cfg(1, 32'h0000_0002);
    write_cfg(2, 32'h0521_0003);
    write_cfg(3, 32'h0000_0004);

    for (int v = 0; v < 8; v++) begin
      gen(int'(VEC[v][30:28]), int'(VEC[v][27:24]), VEC[v][15:0]);
      run_pkt(VEC[v][31], mode_tag(int'(VEC[v][30:28])));
    end

    // R4: path bits inside the mask change the hash, bits above it do not
    gen(2, 6, 16'h9999);
    run_pkt(1'b0, "R4");
    h1 = rx_d[0][31:0];
    pkt[5][48] = ~pkt[5][48];
    run_pkt(1'b0, "R4");
    h2 = rx_d[0][31:0];
    chk(h1 != h2, "R4 path bits alter hash", 64'(h2), 64'(h1));
    pkt[5][55] = ~pkt[5][55];
    run_pkt(1'b1, "R4");
    chk(rx_d[0][31:0] == h2, "R4 bits above width ignored", 64'(rx_d[0][31:0]), 64'(h2));

    // R4: width clamps
    write_cfg(2, 32'h0021_0003);
    gen(2, 6, 16'hABCD);
    run_pkt(1'b0, "R4 width zero");
    write_cfg(2, 32'h0C21_0003);
    run_pkt(1'b1, "R4 width large");

    // R8: short packets
    gen(0, 2, 16'h0F0F);
    run_pkt(1'b0, "R8 short generic");
    gen(0, 1, 16'h0000);
    run_pkt(1'b1, "R8 metadata only");
    gen(1, 2, 16'h1357);
    run_pkt(1'b0, "R8 short flow");

    // R10: writing plane 3 leaves plane 0 intact
    write_cfg(3, 32'h0000_0005);
    gen(0, 6, 16'h2468);
    run_pkt(1'b0, "R10 plane 0 unaffected");
    gen(3, 6, 16'h2468);
    run_pkt(1'b1, "R6 unsupported mode");

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule